// File: doc/BRIEF.md
# Streaming Multiply-Accumulate-Offset Pipeline

This block evaluates the expression A times B plus C on unsigned fixed-point operands and accepts a new operand set on every clock. Work is split over three register stages. The first stage holds A and B. The second stage holds their product. The addend enters the second stage directly from the input port, so C for a given item arrives one cycle after that item's A and B. The third stage holds the sum, and this sum drives the result port.

A valid flag moves through the stages together with the data. The result therefore appears exactly three cycles after its A and B were offered. Empty input slots travel through the pipe as empty output slots. The result is 2N+1 bits wide, which is wide enough that no carry is lost. The block has no backpressure and does not saturate.

Top module: `mac_stream`

## Requirements
- R1: A synchronous, active-high `rst` clears every stage's valid flag. `out_valid` is 0 in the cycle after any clock edge at which `rst` was high, including the edge that interrupts a stream.
- R2: If `in_valid` is high in cycle t, `out_valid` is high in cycle t+3. If `in_valid` is low in cycle t, `out_valid` is low in cycle t+3.
- R3: For an item whose A and B are offered in cycle t, `out_result` in cycle t+3 equals A*B + C, where C is the value on `in_c` in cycle t+1. The value on `in_c` in cycle t has no effect on that item.
- R4: `out_result` is 2N+1 bits wide and holds the exact sum. With all operand bits set (N=8: 255*255+65535 = 130560), no bit is lost.
- R5: Seven or more items offered in consecutive cycles each give their own correct result, in consecutive cycles and in the same order.
- R6: Idle input slots (`in_valid` low), mixed in among valid items, give `out_valid` low in the matching output cycles. The results of the neighbouring valid items stay correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A and B of a new item are present this cycle |
| in_a | input | N | Multiplicand, unsigned |
| in_b | input | N | Multiplier, unsigned |
| in_c | input | 2N | Addend, unsigned; belongs to the item offered one cycle earlier |
| out_valid | output | 1 | `out_result` holds a completed item |
| out_result | output | 2N+1 | A*B + C, unsigned |

## Verification
The assertions take it as given that the source drives the addend for each item one cycle after that item's A and B. They also take it as given that the source never holds back or repeats a slot, because the block has no way to stall. The stimulus keeps to these rules by placing every addend in the cycle after its item. In cycles where the addend belongs to no item, the stimulus fills `in_c` with a distinct junk value, which shows whether the wrong cycle's addend was captured. During reset the stimulus holds `in_valid` low.

// File: rtl/mac_stream.sv
module mac_stream #(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [N-1:0]     in_a,
  input  logic [N-1:0]     in_b,
  input  logic [2*N-1:0]   in_c,
  output logic             out_valid,
  output logic [2*N:0]     out_result
);
  localparam int PW = 2 * N;
  localparam int RW = PW + 1;

  logic [N-1:0]  op_a, op_b;
  logic [PW-1:0] prod, addend;
  logic [RW-1:0] sum;
  logic          v_cap, v_mul, v_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_cap <= 1'b0;
      v_mul <= 1'b0;
      v_sum <= 1'b0;
    end else begin
      v_cap <= in_valid;
      v_mul <= v_cap;
      v_sum <= v_mul;
    end
  end

  always_ff @(posedge clk) begin
    op_a   <= in_a;
    op_b   <= in_b;
    prod   <= PW'(op_a) * PW'(op_b);
    addend <= in_c;
    sum    <= RW'(prod) + RW'(addend);
  end

  assign out_valid  = v_sum;
  assign out_result = sum;

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !out_valid);
  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);
  // R6
  bubble_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid);
  // R3
  result_value_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_result ==
      RW'($past(in_a, 3)) * RW'($past(in_b, 3)) + RW'($past(in_c, 2)));
endmodule

// File: tb/test_mac_stream.sv
`timescale 1ns/1ps
module test_mac_stream;
  localparam int N = 8;
  localparam int W = 2 * N + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_a = '0, in_b = '0;
  logic [2*N-1:0] in_c = '0;
  logic out_valid;
  logic [W-1:0] out_result;

  int checks = 0;
  int errors = 0;

  logic         sv [16];
  logic [N-1:0] sa [16], sb [16];
  logic [2*N-1:0] sc [16];

  mac_stream #(.N(N)) i_mac_stream (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_c(in_c), .out_valid(out_valid), .out_result(out_result)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(int j);
    return W'(sa[j]) * W'(sb[j]) + W'(sc[j]);
  endfunction

  task automatic clear_items();
    for (int i = 0; i < 16; i++) begin
      sv[i] = 1'b0; sa[i] = '0; sb[i] = '0; sc[i] = '0;
    end
  endtask

  task automatic run_seq(string req, int len);
    for (int k = 0; k < len + 4; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        int j = k - 3;
        chk(req, W'(out_valid), W'(sv[j]));
        if (sv[j]) chk(req, out_result, model(j));
      end else begin
        chk(req, W'(out_valid), '0);
      end
      in_valid = (k < len) ? sv[k] : 1'b0;
      in_a     = (k < len) ? sa[k] : '1;
      in_b     = (k < len) ? sb[k] : '1;
      in_c     = (k >= 1 && k - 1 < len) ? sc[k-1] : 16'hBEEF;
    end
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", W'(out_valid), '0);
    repeat (3) begin
      @(negedge clk);
      chk("R1 idle after reset", W'(out_valid), '0);
    end
  endtask

  task automatic test_single();
    clear_items();
    sv[0] = 1'b1; sa[0] = 8'd3; sb[0] = 8'd5; sc[0] = 16'd7;
    run_seq("R2 R3 single item", 1);
  endtask

  task automatic test_max();
    clear_items();
    sv[0] = 1'b1; sa[0] = 8'hFF; sb[0] = 8'hFF; sc[0] = 16'hFFFF;
    sv[1] = 1'b1; sa[1] = 8'hFF; sb[1] = 8'h01; sc[1] = 16'h0000;
    run_seq("R4 full width", 2);
    chk("R4 constant", model(0), 17'd130560);
  endtask

  task automatic test_stream();
    clear_items();
    for (int i = 0; i < 7; i++) begin
      sv[i] = 1'b1;
      sa[i] = N'(i * 37 + 11);
      sb[i] = N'(200 - i * 19);
      sc[i] = 16'(i * 4099 + 123);
    end
    run_seq("R5 back-to-back", 7);
  endtask

  task automatic test_bubbles();
    clear_items();
    for (int i = 0; i < 9; i++) begin
      sa[i] = N'(i * 53 + 2);
      sb[i] = N'(i * 29 + 7);
      sc[i] = 16'(i * 7001 + 5);
    end
    sv[0] = 1'b1; sv[2] = 1'b1; sv[3] = 1'b1; sv[6] = 1'b1; sv[8] = 1'b1;
    run_seq("R6 bubbles", 9);
  endtask

  task automatic test_mid_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_a = N'(k + 4); in_b = N'(k + 9); in_c = 16'h1234;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R1 mid-stream reset", W'(out_valid), '0);
      @(negedge clk);
    end
  endtask

  initial begin
    test_reset();
    test_single();
    test_max();
    test_stream();
    test_bubbles();
    test_mid_reset();
    test_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule